// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the bus-master control registers of one channel of a two-channel disk DMA controller. The registers sit in an 8-byte window that a host reaches through a simple I/O access port. The window holds a command byte, a status byte, a 32-bit descriptor-table pointer and two spare bytes. Host reads are combinational. Host writes take effect at the clock edge.

The block does not move data or walk descriptors. When the host flips the start bit of the command byte, the block tells a DMA engine to launch or abort a transfer. It does this with one-cycle pulses, and the launch pulse carries the aligned table pointer. The engine reports completion and faults back through single-cycle inputs. A device interrupt input sets a sticky interrupt flag. Software clears the interrupt and fault flags by writing a one to them.

Access encoding: `acc_size` 0 means one byte, 1 means two bytes, and 2 (or 3, for reads) means four bytes. Command is at offset 0, status at offset 2, and the pointer at offset 4. Command bit 0 is the start bit. In the status byte, bit 0 is the active flag, bit 1 the fault flag and bit 2 the interrupt flag. Bits 5 and 6 are the DMA-capability bits.

Top module: `bm_chan_regs`

## Requirements
- R1: After reset the command byte, both spare bytes and the pointer are zero. The status byte reads 0x60: only the two capability bits (5 and 6) are set.
- R2: A read returns the window shifted right by `acc_addr` bytes and masked to the access size. Size code 0 gives 8 bits, code 1 gives 16 bits, and codes 2 and 3 give 32 bits. The window holds the command at byte 0, spare byte at 1, status at 2, spare byte at 3 and pointer at bytes 4 to 7. Single-byte writes to offsets 1 and 3 store the byte.
- R3: Only two kinds of write are legal: a single-byte write at offsets 0 to 3, and a four-byte write at offset 4. Any other write changes no register and raises `acc_err` for the one cycle after the write edge.
- R4: A pointer write stores the data with bits 1:0 forced to zero.
- R5: A command write that moves the start bit from 0 to 1, with `dev_sel` high, does two things. It sets the active flag. It also raises `start_pulse` for one cycle, with `start_ptr` equal to the stored pointer.
- R6: A command write that moves the start bit from 1 to 0, with `dev_sel` high, clears the active flag and raises `abort_pulse` for one cycle.
- R7: A command write that changes the start bit while `dev_sel` is low is rejected. It raises `acc_err`, issues no pulse and leaves the command and status bytes unchanged.
- R8: A host status write never changes the active flag.
- R9: The interrupt flag and the fault flag clear only when a 1 is written to a set flag. Writing 0 leaves them as they are. Status bits 3 to 7 store the written value.
- R10: A `dma_done` cycle clears the start bit and the active flag and sets the interrupt flag. It issues no pulse.
- R11: `dev_irq` sets the interrupt flag. `dma_fault` sets the fault flag.
- R12: If a set event and a write-one-to-clear hit the same flag in the same cycle, the flag stays set.
- R13: A command write that leaves the start bit unchanged stores the byte and issues no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Host access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Byte offset in the window |
| acc_size | input | 2 | Access size code (0: 1 B, 1: 2 B, 2: 4 B) |
| acc_wdata | input | 32 | Write data, least significant byte at the offset |
| acc_rdata | output | 32 | Read data, zero when no read is in progress |
| acc_err | output | 1 | One-cycle error flag for a rejected write |
| dev_sel | input | 1 | A device is selected on the channel |
| dev_irq | input | 1 | Device interrupt, sets the interrupt flag |
| dma_done | input | 1 | Engine completion |
| dma_fault | input | 1 | Engine fault, sets the fault flag |
| start_pulse | output | 1 | Launch request to the engine |
| abort_pulse | output | 1 | Abort request to the engine |
| start_ptr | output | 32 | Descriptor-table pointer for the engine |

## Verification
The bench goes after the edge detection on the start bit. If the design tested the level of the start bit rather than a change, rewriting the same start value would emit a second pulse. If it compared against the wrong old value, a real stop would emit no abort. Write-one-to-clear is tested with both data polarities. A design that stored the written value would clear a flag on a 0 write. It would also let software set the active flag or a flag that was clear. Illegal sizes, and start changes with no device selected, are both shown to leave every byte intact. The bench also drives a device interrupt in the same cycle as a clear write: a design with the wrong priority would drop a fresh interrupt.

// File: rtl/bm_regs_pkg.sv
// Shared constants and types for the bus-master channel register block.
// Assumes an 8-byte window and byte-wide command and status registers.
package bm_regs_pkg;
    localparam int BYTE_W = 8;

    // Byte offsets inside the window; software decodes these
    localparam logic [2:0] OFS_CMD  = 3'd0;
    localparam logic [2:0] OFS_RSV1 = 3'd1;
    localparam logic [2:0] OFS_STS  = 3'd2;
    localparam logic [2:0] OFS_RSV3 = 3'd3;
    localparam logic [2:0] OFS_PTR  = 3'd4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    // Field positions
    localparam int CMD_GO_BIT    = 0;
    localparam int STS_ACT_BIT   = 0;
    localparam int STS_FAULT_BIT = 1;
    localparam int STS_IRQ_BIT   = 2;

    // Status reset value: capability bits 5 and 6 set
    localparam logic [BYTE_W-1:0] STS_RESET = 8'h60;
    // Status bits that are plain storage
    localparam logic [BYTE_W-1:0] STS_PLAIN_MASK = 8'hF8;

    // One-hot write target produced by the decoder
    typedef struct packed {
        logic cmd;
        logic rsv1;
        logic sts;
        logic rsv3;
        logic ptr;
        logic bad;
    } wr_sel_t;
endpackage

// File: rtl/bm_wr_decode.sv
// Write decoder: turns one host access into a register write strobe,
// or flags it as illegal. Legal writes are single bytes at offsets 0..3
// and a four-byte write at offset 4. Reads produce no strobe.
module bm_wr_decode
    import bm_regs_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    output wr_sel_t           sel
);
    // Classify the access by size and offset
    always_comb begin
        sel = '0;
        if (acc_valid && acc_write) begin
            if (acc_size == SZ_BYTE) begin
                if (acc_addr == ADDR_W'(OFS_CMD))       sel.cmd  = 1'b1;
                else if (acc_addr == ADDR_W'(OFS_RSV1)) sel.rsv1 = 1'b1;
                else if (acc_addr == ADDR_W'(OFS_STS))  sel.sts  = 1'b1;
                else if (acc_addr == ADDR_W'(OFS_RSV3)) sel.rsv3 = 1'b1;
                else                                    sel.bad  = 1'b1;
            end else if (acc_size == SZ_WORD && acc_addr == ADDR_W'(OFS_PTR)) begin
                sel.ptr = 1'b1;
            end else begin
                sel.bad = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bm_cmd_unit.sv
// Command byte and active flag. Detects changes of the start bit on
// host writes and turns them into launch or abort pulses. A change
// while no device is selected is rejected whole. Engine completion
// clears the start bit and the active flag and takes priority over
// the host for those two bits.
module bm_cmd_unit
    import bm_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              dev_sel,
    input  logic              dma_done,
    output logic [BYTE_W-1:0] cmd_q,
    output logic              active_q,
    output logic              start_pulse,
    output logic              abort_pulse,
    output logic              sel_err
);
    logic              flip;
    logic              go;
    logic [BYTE_W-1:0] cmd_d;
    logic              act_d;

    // Start-bit change detection and acceptance
    always_comb begin
        flip    = wr_en && (wr_byte[CMD_GO_BIT] != cmd_q[CMD_GO_BIT]);
        sel_err = flip && !dev_sel;
        go      = flip && dev_sel;
    end

    // Next command byte and active flag, completion last so it wins
    always_comb begin
        cmd_d = cmd_q;
        act_d = active_q;
        if (wr_en && !sel_err) cmd_d = wr_byte;
        if (go)                act_d = wr_byte[CMD_GO_BIT];
        if (dma_done) begin
            cmd_d[CMD_GO_BIT] = 1'b0;
            act_d             = 1'b0;
        end
    end

    // State and pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q       <= '0;
            active_q    <= 1'b0;
            start_pulse <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            cmd_q       <= cmd_d;
            active_q    <= act_d;
            start_pulse <= go &&  wr_byte[CMD_GO_BIT];
            abort_pulse <= go && !wr_byte[CMD_GO_BIT];
        end
    end
endmodule

// File: rtl/bm_sts_unit.sv
// Status byte apart from the active flag, which is supplied from
// outside. The interrupt and fault flags are sticky. A host write of 1
// clears a flag, and a set event in the same cycle wins. Bits 3..7
// are plain storage, with the capability bits set at reset.
module bm_sts_unit
    import bm_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              set_irq,
    input  logic              set_fault,
    input  logic              active,
    output logic [BYTE_W-1:0] sts_byte,
    output logic              irq_q,
    output logic              fault_q
);
    logic [BYTE_W-1:0] plain_q;
    logic              irq_d;
    logic              fault_d;

    // Sticky flag update: clear on a written 1, set wins
    always_comb begin
        irq_d   = (irq_q   && !(wr_en && wr_byte[STS_IRQ_BIT]))   || set_irq;
        fault_d = (fault_q && !(wr_en && wr_byte[STS_FAULT_BIT])) || set_fault;
    end

    // Status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plain_q <= STS_RESET & STS_PLAIN_MASK;
            irq_q   <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            if (wr_en) plain_q <= wr_byte & STS_PLAIN_MASK;
            irq_q   <= irq_d;
            fault_q <= fault_d;
        end
    end

    // Assemble the byte seen by readers
    always_comb begin
        sts_byte                = plain_q & STS_PLAIN_MASK;
        sts_byte[STS_IRQ_BIT]   = irq_q;
        sts_byte[STS_FAULT_BIT] = fault_q;
        sts_byte[STS_ACT_BIT]   = active;
    end
endmodule

// File: rtl/bm_chan_regs.sv
// Top of the per-channel bus-master register block. Owns the pointer
// and spare bytes, the write-error flag and the read path. It
// instantiates the write decoder, the command unit and the status unit.
// Assumes one access per valid cycle and a combinational read.
module bm_chan_regs
    import bm_regs_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int PTR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_err,
    input  logic              dev_sel,
    input  logic              dev_irq,
    input  logic              dma_done,
    input  logic              dma_fault,
    output logic              start_pulse,
    output logic              abort_pulse,
    output logic [PTR_W-1:0]  start_ptr
);
    localparam int WIN_W   = PTR_W + 4 * BYTE_W;
    localparam int ALIGN_B = 2;

    wr_sel_t           sel;
    logic [BYTE_W-1:0] cmd_q;
    logic              cmd_start;
    logic              sts_act;
    logic              sts_irq;
    logic              sts_fault;
    logic [BYTE_W-1:0] sts_byte;
    logic              sel_err;
    logic [BYTE_W-1:0] rsv1_q;
    logic [BYTE_W-1:0] rsv3_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [WIN_W-1:0]  window;
    logic [WIN_W-1:0]  shifted;
    logic [DATA_W-1:0] rd_mask;

    bm_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .sel       (sel)
    );

    bm_cmd_unit u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (sel.cmd),
        .wr_byte     (acc_wdata[BYTE_W-1:0]),
        .dev_sel     (dev_sel),
        .dma_done    (dma_done),
        .cmd_q       (cmd_q),
        .active_q    (sts_act),
        .start_pulse (start_pulse),
        .abort_pulse (abort_pulse),
        .sel_err     (sel_err)
    );

    bm_sts_unit u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sel.sts),
        .wr_byte   (acc_wdata[BYTE_W-1:0]),
        .set_irq   (dev_irq || dma_done),
        .set_fault (dma_fault),
        .active    (sts_act),
        .sts_byte  (sts_byte),
        .irq_q     (sts_irq),
        .fault_q   (sts_fault)
    );

    assign cmd_start = cmd_q[CMD_GO_BIT];
    assign start_ptr = ptr_q;

    // Pointer, spare bytes and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            rsv1_q  <= '0;
            rsv3_q  <= '0;
            acc_err <= 1'b0;
        end else begin
            if (sel.ptr)  ptr_q  <= {acc_wdata[PTR_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
            if (sel.rsv1) rsv1_q <= acc_wdata[BYTE_W-1:0];
            if (sel.rsv3) rsv3_q <= acc_wdata[BYTE_W-1:0];
            acc_err <= sel.bad || sel_err;
        end
    end

    // Read path: shift the window to the offset and mask to the size
    always_comb begin
        window  = {ptr_q, rsv3_q, sts_byte, rsv1_q, cmd_q};
        shifted = window >> {acc_addr, 3'b000};
        case (acc_size)
            SZ_BYTE: rd_mask = DATA_W'({BYTE_W{1'b1}});
            SZ_HALF: rd_mask = DATA_W'({2 * BYTE_W{1'b1}});
            default: rd_mask = '1;
        endcase
        acc_rdata = (acc_valid && !acc_write) ? (shifted[DATA_W-1:0] & rd_mask) : '0;
    end
endmodule

// File: rtl/bm_chan_regs_chk.sv
// Property checker for the bus-master channel register block, bound
// to the top so it can watch the command and status state.
module bm_chan_regs_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int PTR_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        acc_size,
    input logic [DATA_W-1:0] acc_wdata,
    input logic              acc_err,
    input logic              dev_sel,
    input logic              dev_irq,
    input logic              dma_done,
    input logic              start_pulse,
    input logic              abort_pulse,
    input logic [PTR_W-1:0]  start_ptr,
    input logic              cmd_start,
    input logic              sts_act,
    input logic              sts_irq
);
    // R5
    start_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> sts_act);

    // R6
    abort_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> !sts_act);

    // R5
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_pulse && abort_pulse));

    // R4
    ptr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (start_ptr[1:0] == 2'b00));

    // R7
    no_device_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr == '0 && acc_size == 2'd0
         && acc_wdata[0] != cmd_start && !dev_sel)
        |=> (acc_err && !start_pulse && !abort_pulse));

    // R8
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr == ADDR_W'(2) && !dma_done)
        |=> $stable(sts_act));

    // R10
    done_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |=> (!cmd_start && !sts_act && sts_irq && !start_pulse && !abort_pulse));

    // R11
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_irq |=> sts_irq);
endmodule

bind bm_chan_regs bm_chan_regs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_addr    (acc_addr),
    .acc_size    (acc_size),
    .acc_wdata   (acc_wdata),
    .acc_err     (acc_err),
    .dev_sel     (dev_sel),
    .dev_irq     (dev_irq),
    .dma_done    (dma_done),
    .start_pulse (start_pulse),
    .abort_pulse (abort_pulse),
    .start_ptr   (start_ptr),
    .cmd_start   (cmd_start),
    .sts_act     (sts_act),
    .sts_irq     (sts_irq)
);

// File: tb/bm_chan_regs_test.sv
`timescale 1ns/1ps
module bm_chan_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [2:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_err;
    logic        dev_sel = 1'b1;
    logic        dev_irq = 1'b0;
    logic        dma_done = 1'b0;
    logic        dma_fault = 1'b0;
    logic        start_pulse;
    logic        abort_pulse;
    logic [31:0] start_ptr;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bm_chan_regs uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_err(acc_err), .dev_sel(dev_sel),
        .dev_irq(dev_irq), .dma_done(dma_done), .dma_fault(dma_fault),
        .start_pulse(start_pulse), .abort_pulse(abort_pulse), .start_ptr(start_ptr)
    );

    // One table row: write (checks flags next cycle) or read (checks data)
    typedef struct packed {
        logic        wr;
        logic [2:0]  a;
        logic [1:0]  sz;
        logic [31:0] d;
        logic        e_err;
        logic        e_st;
        logic        e_ab;
        logic [31:0] e_rd;
    } vec_t;

    localparam logic [31:0] PTR_EXP = 32'h1234_5674;
    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd2, 2'd0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h60},       // R1 status reset
        '{1'b0, 3'd0, 2'd2, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0060_0000},// R2 word read at 0
        '{1'b1, 3'd4, 2'd2, 32'h1234_5677, 1'b0, 1'b0, 1'b0, 32'h0},        // R4 pointer write
        '{1'b0, 3'd4, 2'd2, 32'h0,         1'b0, 1'b0, 1'b0, PTR_EXP},      // R4 aligned
        '{1'b1, 3'd4, 2'd0, 32'hFF,        1'b1, 1'b0, 1'b0, 32'h0},        // R3 byte at ptr
        '{1'b0, 3'd4, 2'd2, 32'h0,         1'b0, 1'b0, 1'b0, PTR_EXP},      // R3 unchanged
        '{1'b1, 3'd0, 2'd1, 32'h0009,      1'b1, 1'b0, 1'b0, 32'h0},        // R3 half to cmd
        '{1'b0, 3'd0, 2'd0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h00},       // R3 cmd kept
        '{1'b1, 3'd1, 2'd0, 32'hA5,        1'b0, 1'b0, 1'b0, 32'h0},        // R2 spare byte
        '{1'b0, 3'd0, 2'd1, 32'h0,         1'b0, 1'b0, 1'b0, 32'hA500},     // R2 half read
        '{1'b1, 3'd0, 2'd0, 32'h09,        1'b0, 1'b1, 1'b0, 32'h0},        // R5 start
        '{1'b0, 3'd2, 2'd0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h61},       // R5 active
        '{1'b1, 3'd2, 2'd0, 32'h60,        1'b0, 1'b0, 1'b0, 32'h0},        // R8 try clear active
        '{1'b0, 3'd2, 2'd0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h61},       // R8 still active
        '{1'b1, 3'd0, 2'd0, 32'h09,        1'b0, 1'b0, 1'b0, 32'h0},        // R13 same start
        '{1'b1, 3'd0, 2'd0, 32'h08,        1'b0, 1'b0, 1'b1, 32'h0},        // R6 stop
        '{1'b0, 3'd0, 2'd0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h08},       // R6 cmd byte
        '{1'b0, 3'd2, 2'd0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h60},       // R6 inactive
        '{1'b1, 3'd0, 2'd0, 32'h00,        1'b0, 1'b0, 1'b0, 32'h0},        // R13 dir only
        '{1'b0, 3'd0, 2'd0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h00},       // R13 stored
        '{1'b1, 3'd3, 2'd0, 32'h3C,        1'b0, 1'b0, 1'b0, 32'h0},        // R2 spare byte 3
        '{1'b0, 3'd2, 2'd1, 32'h0,         1'b0, 1'b0, 1'b0, 32'h3C60},     // R2 half at 2
        '{1'b1, 3'd5, 2'd0, 32'h11,        1'b1, 1'b0, 1'b0, 32'h0},        // R3 byte at 5
        '{1'b1, 3'd6, 2'd1, 32'h1111,      1'b1, 1'b0, 1'b0, 32'h0},        // R3 half at 6
        '{1'b1, 3'd0, 2'd2, 32'h01,        1'b1, 1'b0, 1'b0, 32'h0},        // R3 word at 0
        '{1'b0, 3'd0, 2'd2, 32'h0,         1'b0, 1'b0, 1'b0, 32'h3C60_A500} // R3 nothing moved
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Write: drive at a falling edge, sample registered outputs one cycle later
    task automatic wr(input logic [2:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = sz; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    // Read: combinational data sampled before the next rising edge
    task automatic rd(input logic [2:0] a, input logic [1:0] sz, output logic [31:0] v);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = sz;
        #1 v = acc_rdata;
        acc_valid = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                wr(VECS[i].a, VECS[i].sz, VECS[i].d);
                check($sformatf("vec%0d err", i), {31'b0, acc_err}, {31'b0, VECS[i].e_err});
                check($sformatf("vec%0d start", i), {31'b0, start_pulse}, {31'b0, VECS[i].e_st});
                check($sformatf("vec%0d abort", i), {31'b0, abort_pulse}, {31'b0, VECS[i].e_ab});
                if (VECS[i].e_st) check("R5 start_ptr", start_ptr, PTR_EXP);
            end else begin
                rd(VECS[i].a, VECS[i].sz, v);
                check($sformatf("vec%0d read", i), v, VECS[i].e_rd);
            end
        end

        // R7: start change with no device selected
        dev_sel = 1'b0;
        wr(3'd0, 2'd0, 32'h01);
        check("R7 err", {31'b0, acc_err}, 32'd1);
        check("R7 no pulse", {30'b0, start_pulse, abort_pulse}, 32'd0);
        rd(3'd0, 2'd0, v); check("R7 cmd kept", v, 32'h00);
        rd(3'd2, 2'd0, v); check("R7 status kept", v, 32'h60);
        dev_sel = 1'b1;

        // R10: completion after a launch
        wr(3'd0, 2'd0, 32'h01);
        check("R10 launch", {31'b0, start_pulse}, 32'd1);
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
        check("R10 no pulse", {30'b0, start_pulse, abort_pulse}, 32'd0);
        rd(3'd0, 2'd0, v); check("R10 start cleared", v, 32'h00);
        rd(3'd2, 2'd0, v); check("R10 irq set, inactive", v, 32'h64);

        // R9: write-one-to-clear and plain bits
        wr(3'd2, 2'd0, 32'h64);
        rd(3'd2, 2'd0, v); check("R9 irq cleared", v, 32'h60);
        @(negedge clk); dma_fault = 1'b1;
        @(negedge clk); dma_fault = 1'b0;
        rd(3'd2, 2'd0, v); check("R11 fault set", v, 32'h62);
        wr(3'd2, 2'd0, 32'h60);
        rd(3'd2, 2'd0, v); check("R9 zero keeps fault", v, 32'h62);
        wr(3'd2, 2'd0, 32'h62);
        rd(3'd2, 2'd0, v); check("R9 fault cleared", v, 32'h60);
        wr(3'd2, 2'd0, 32'h86);
        rd(3'd2, 2'd0, v); check("R9 plain bits, no set by write", v, 32'h80);
        wr(3'd2, 2'd0, 32'h60);

        // R11: device interrupt
        @(negedge clk); dev_irq = 1'b1;
        @(negedge clk); dev_irq = 1'b0;
        rd(3'd2, 2'd0, v); check("R11 irq set", v, 32'h64);

        // R12: set and clear in the same cycle
        @(negedge clk);
        dev_irq = 1'b1;
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 3'd2; acc_size = 2'd0; acc_wdata = 32'h64;
        @(negedge clk);
        dev_irq = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
        rd(3'd2, 2'd0, v); check("R12 set wins", v, 32'h64);

        // R1: reset mid-run
        wr(3'd0, 2'd0, 32'h01);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 no pulse", {30'b0, start_pulse, abort_pulse}, 32'd0);
        check("R1 no err", {31'b0, acc_err}, 32'd0);
        rd(3'd0, 2'd2, v); check("R1 low word", v, 32'h0060_0000);
        rd(3'd4, 2'd2, v); check("R1 pointer", v, 32'h0);

        summary();
    end
endmodule